// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer

This block is the digital half of an 8-bit successive-approximation converter on a small byte-wide register bus. Software writes one control byte that picks the input channel, powers the converter and picks its conversion clock. The block then converts that channel over and over. On each conversion it drives a trial code to an external comparator, reads back one decision bit, and latches the finished code into a read-only result register. Each new result raises a completion flag. The flag drops when software reads the result or writes the control byte.

The block has one clock domain. The two possible conversion clocks, the processor clock and a slow RC oscillator, arrive as clock-enable strobes. A two-bit selection picks one of four states: off, processor clock, oscillator warm-up (oscillator on, converter idle) or oscillator clock. The converter counter advances only on the strobe that the current state selects. The processor clock suits bus rates of 1 MHz and above. The oscillator suits slower buses.

The register bus is a plain strobe interface with no handshake. The comparator bit, the trial code, the sampling strobe and the channel number are level signals with no valid/ready flow control. The converter never waits for a reader: a result that is not read is overwritten by the next one.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, both the control register (address 0x4F) and the result register (address 0x4E) read 0x00, and the completion flag is clear.
- R2: Reading address 0x4F returns the completion flag in bit 7, oscillator select in bit 6, power in bit 5, constant 0 in bit 4 and the channel in bits 3:0. Writes to bits 7 and 4 have no effect. Any other address reads 0x00.
- R3: A conversion lasts exactly 32 selected-clock strobes. The flag sets on the 32nd strobe after the conversion starts.
- R4: Result bits are resolved most significant first, one per strobe, on strobes 9 to 16. During each of these the trial code equals the bits kept so far with the bit under test set. A bit is kept when the comparator input is 1.
- R5: When a conversion completes, the next one on the same channel starts on the following strobe with no software action.
- R6: A read of address 0x4E or any write to address 0x4F clears the flag. A completion in the same cycle as a result read leaves the flag set.
- R7: With {bit6, bit5} = 00 the converter is off. With 01 it steps on the processor-clock strobe. With 10 it stays idle and only the oscillator-enable output is high. With 11 it steps on the oscillator strobe, and the processor strobe is ignored.
- R8: The sampling output is high during the first 8 strobes of each conversion and low for the rest of the conversion.
- R9: A write to the control register aborts the conversion in progress. If power is on, it starts a full 32-strobe conversion on the newly written channel.
- R10: While power is off, the trial code and the sampling output stay at 0. The result register keeps its last value.
- R11: The channel output always equals control bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears the flag when it hits the result) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| cpu_tick | input | 1 | Processor-clock conversion strobe |
| osc_tick | input | 1 | RC-oscillator conversion strobe |
| osc_enable | output | 1 | Turns the RC oscillator on |
| sample_on | output | 1 | Sampling phase of the current conversion |
| chan_sel | output | 4 | Channel for the analog multiplexer |
| trial_code | output | 8 | Code presented to the comparator DAC |
| cmp_hit | input | 1 | Comparator decision: 1 means input is at or above the trial level |

## Verification
The bench builds the block with its default parameters: an 8-bit code, 32-strobe conversions and 8 sampling strobes. With these values the exact 32-strobe completion edge can be counted in a short run, both on the always-on processor strobe and on a hand-pulsed oscillator strobe. The comparator model, a per-channel level compared with the trial code, makes every result equal to a chosen level. That lets the all-zero and all-one codes, back-to-back restarts and an aborted conversion each show up as a distinct expected value.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam int CHAN_W = 4;
  localparam int BIT_FLAG = 7;
  localparam int BIT_OSC  = 6;
  localparam int BIT_PWR  = 5;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_CPU  = 2'b01,
    SRC_WARM = 2'b10,
    SRC_OSC  = 2'b11
  } clk_src_e;
endpackage

// File: rtl/sar_clk_sel.sv
module sar_clk_sel
  import sar_adc_pkg::*;
(
  input  logic osc_sel,
  input  logic pwr_on,
  input  logic cpu_tick,
  input  logic osc_tick,
  output logic run,
  output logic step,
  output logic osc_enable
);
  clk_src_e src;
  assign src = clk_src_e'({osc_sel, pwr_on});

  always_comb begin
    run        = 1'b0;
    step       = 1'b0;
    osc_enable = 1'b0;
    unique case (src)
      SRC_OFF:  ;
      SRC_CPU:  begin run = 1'b1; step = cpu_tick; end
      SRC_WARM: osc_enable = 1'b1;
      SRC_OSC:  begin run = 1'b1; step = osc_tick; osc_enable = 1'b1; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int DATA_W        = 8,
  parameter int CONV_STEPS    = 32,
  parameter int SAMPLE_STEPS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              step,
  input  logic              restart,
  input  logic              cmp_hit,
  output logic [DATA_W-1:0] trial_code,
  output logic [DATA_W-1:0] code_q,
  output logic              sample_on,
  output logic              done
);
  localparam int CNT_W    = $clog2(CONV_STEPS);
  localparam int RES_LAST = SAMPLE_STEPS + DATA_W - 1;

  logic [CNT_W-1:0]  phase_q;
  logic [DATA_W-1:0] probe;

  // one-hot pointer at the bit resolved in the current phase
  for (genvar i = 0; i < DATA_W; i++) begin : g_probe
    assign probe[i] = run && (phase_q == CNT_W'(RES_LAST - i));
  end

  assign trial_code = code_q | probe;
  assign sample_on  = run && (phase_q < CNT_W'(SAMPLE_STEPS));
  assign done       = run && step && !restart &&
                      (phase_q == CNT_W'(CONV_STEPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      code_q  <= '0;
    end else if (!run || restart || done) begin
      phase_q <= '0;
      code_q  <= '0;
    end else if (step) begin
      phase_q <= phase_q + 1'b1;
      code_q  <= code_q | (probe & {DATA_W{cmp_hit}});
    end
  end
endmodule

// File: rtl/sar_regs.sv
module sar_regs
  import sar_adc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int RES_ADDR  = 'h4E,
  parameter int CTRL_ADDR = 'h4F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              done,
  input  logic [DATA_W-1:0] code_q,
  output logic              osc_sel,
  output logic              pwr_on,
  output logic [CHAN_W-1:0] chan,
  output logic              ctrl_wr,
  output logic              flag_q,
  output logic [DATA_W-1:0] result_q
);
  logic hit_res, hit_ctrl, res_rd;

  assign hit_res  = bus_addr == ADDR_W'(RES_ADDR);
  assign hit_ctrl = bus_addr == ADDR_W'(CTRL_ADDR);
  assign ctrl_wr  = bus_wr && hit_ctrl;
  assign res_rd   = bus_rd && hit_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_sel  <= 1'b0;
      pwr_on   <= 1'b0;
      chan     <= '0;
      flag_q   <= 1'b0;
      result_q <= '0;
    end else begin
      if (ctrl_wr) begin
        osc_sel <= bus_wdata[BIT_OSC];
        pwr_on  <= bus_wdata[BIT_PWR];
        chan    <= bus_wdata[CHAN_W-1:0];
      end
      if (done) begin
        flag_q   <= 1'b1;
        result_q <= code_q;
      end else if (ctrl_wr || res_rd) begin
        flag_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl) begin
      bus_rdata[BIT_FLAG]     = flag_q;
      bus_rdata[BIT_OSC]      = osc_sel;
      bus_rdata[BIT_PWR]      = pwr_on;
      bus_rdata[CHAN_W-1:0]   = chan;
    end else if (hit_res) begin
      bus_rdata = 8'(result_q);
    end
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int CONV_STEPS   = 32,
  parameter int SAMPLE_STEPS = 8,
  parameter int RES_ADDR     = 'h4E,
  parameter int CTRL_ADDR    = 'h4F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              cpu_tick,
  input  logic              osc_tick,
  output logic              osc_enable,
  output logic              sample_on,
  output logic [3:0]        chan_sel,
  output logic [DATA_W-1:0] trial_code,
  input  logic              cmp_hit
);
  logic              osc_sel, pwr_on, run, step, ctrl_wr, done, flag_q;
  logic [DATA_W-1:0] code_q, result_q;

  sar_clk_sel u_clk_sel (
    .osc_sel(osc_sel), .pwr_on(pwr_on), .cpu_tick(cpu_tick),
    .osc_tick(osc_tick), .run(run), .step(step), .osc_enable(osc_enable)
  );

  sar_seq #(.DATA_W(DATA_W), .CONV_STEPS(CONV_STEPS),
            .SAMPLE_STEPS(SAMPLE_STEPS)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .step(step), .restart(ctrl_wr),
    .cmp_hit(cmp_hit), .trial_code(trial_code), .code_q(code_q),
    .sample_on(sample_on), .done(done)
  );

  sar_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_ADDR(RES_ADDR),
             .CTRL_ADDR(CTRL_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .code_q(code_q), .osc_sel(osc_sel), .pwr_on(pwr_on),
    .chan(chan_sel), .ctrl_wr(ctrl_wr), .flag_q(flag_q), .result_q(result_q)
  );
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int RES_ADDR  = 'h4E,
  parameter int CTRL_ADDR = 'h4F
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        bus_rdata,
  input logic              pwr_on,
  input logic              step,
  input logic              done,
  input logic              flag_q,
  input logic              sample_on,
  input logic [DATA_W-1:0] trial_code,
  input logic [DATA_W-1:0] code_q,
  input logic [DATA_W-1:0] result_q
);
  a_r2_bit4_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(CTRL_ADDR)) |-> (bus_rdata[4] == 1'b0));

  a_r3_done_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> step);

  a_r4_one_probe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(trial_code ^ code_q) <= 1);

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(RES_ADDR) && !done) |=> !flag_q);

  a_r6_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag_q);

  a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(CTRL_ADDR)) |=> !flag_q);

  a_r8_sample_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    sample_on |-> pwr_on);

  a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> $stable(result_q));

  a_r10_off_trial_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> (trial_code == '0));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_ADDR(RES_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_rdata(bus_rdata), .pwr_on(pwr_on), .step(step),
  .done(done), .flag_q(flag_q), .sample_on(sample_on),
  .trial_code(trial_code), .code_q(code_q), .result_q(result_q)
);

// File: tb/sar_adc_ctrl_bench.sv
module sar_adc_ctrl_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] bus_addr = 0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       cpu_tick = 1, osc_tick = 0;
  logic       osc_enable, sample_on, cmp_hit;
  logic [3:0] chan_sel;
  logic [7:0] trial_code;
  logic [7:0] level [16];
  logic [7:0] exp_q [$];
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  assign cmp_hit = (trial_code <= level[chan_sel]);

  sar_adc_ctrl u_sar_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_tick(cpu_tick), .osc_tick(osc_tick), .osc_enable(osc_enable),
    .sample_on(sample_on), .chan_sel(chan_sel), .trial_code(trial_code),
    .cmp_hit(cmp_hit)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    bus_addr = 8'h4F; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wait_flag();
    logic [7:0] s;
    for (int i = 0; i < 400; i++) begin
      rd(8'h4F, s);
      if (s[7]) return;
    end
    check("R5 flag timeout", 8'h00, 8'h80);
  endtask

  task automatic push_exp(input logic [7:0] v);
    exp_q.push_back(v);
  endtask

  task automatic collect(input string req);
    logic [7:0] d;
    wait_flag();
    rd(8'h4E, d);
    if (exp_q.size() == 0) check({req, " empty queue"}, d, 8'hxx);
    else check(req, d, exp_q.pop_front());
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < 16; i++) level[i] = 8'(i * 16 + 3);
    level[0] = 8'hA5;
    idle(2);
    rst_n = 1;
    idle(1);
    rd(8'h4F, d); check("R1 ctrl reset", d, 8'h00);
    rd(8'h4E, d); check("R1 result reset", d, 8'h00);

    // processor clock, channel 0: sampling, MSB-first trials, exact length
    wr_ctrl(8'h20);
    check("R8 sampling at start", {7'd0, sample_on}, 8'h01);
    idle(7); check("R8 sampling strobe 8", {7'd0, sample_on}, 8'h01);
    idle(1); check("R8 sampling ends", {7'd0, sample_on}, 8'h00);
    check("R4 first trial", trial_code, 8'h80);
    idle(1); check("R4 second trial", trial_code, 8'hC0);
    idle(22);
    rd(8'h4F, d); check("R3 no flag at strobe 31", d, 8'h20);
    rd(8'h4F, d); check("R3 flag at strobe 32", d, 8'hA0);
    push_exp(8'hA5); collect("R4 result A5");
    rd(8'h4F, d); check("R6 read clears flag", d, 8'h20);

    // automatic restarts with boundary codes
    level[0] = 8'h00; push_exp(8'h00); collect("R5 restart zero code");
    level[0] = 8'hFF; push_exp(8'hFF); collect("R5 restart full code");

    // control write clears flag
    wait_flag();
    wr_ctrl(8'h20);
    rd(8'h4F, d); check("R6 write clears flag", d, 8'h20);

    // abort and restart on new channel
    level[1] = 8'h11; level[2] = 8'h77;
    wr_ctrl(8'h21); idle(12);
    wr_ctrl(8'h22);
    check("R11 channel out", {4'd0, chan_sel}, 8'h02);
    idle(31);
    rd(8'h4F, d); check("R9 no flag before full window", d, 8'h22);
    rd(8'h4F, d); check("R9 flag after full window", d, 8'hA2);
    push_exp(8'h77); collect("R9 result from new channel");

    // power off keeps result
    wr_ctrl(8'h00);
    idle(60);
    check("R10 trial zero off", trial_code, 8'h00);
    check("R10 sampling low off", {7'd0, sample_on}, 8'h00);
    rd(8'h4E, d); check("R10 result kept", d, 8'h77);

    // warm-up state, read-only bits, unmapped address
    wr_ctrl(8'hDF);
    rd(8'h4F, d); check("R2 layout after write DF", d, 8'h4F);
    check("R7 osc on in warm-up", {7'd0, osc_enable}, 8'h01);
    check("R11 channel F", {4'd0, chan_sel}, 8'h0F);
    idle(100);
    rd(8'h4F, d); check("R7 warm-up stays idle", d, 8'h4F);
    check("R7 warm-up no sampling", {7'd0, sample_on}, 8'h00);
    rd(8'h10, d); check("R2 unmapped reads zero", d, 8'h00);

    // oscillator clock: processor strobe ignored
    level[1] = 8'h3C;
    wr_ctrl(8'h61);
    idle(50);
    rd(8'h4F, d); check("R7 cpu strobe ignored", d, 8'h61);
    for (int i = 0; i < 31; i++) begin
      osc_tick = 1; @(negedge clk); osc_tick = 0; @(negedge clk);
    end
    rd(8'h4F, d); check("R3 osc no flag at 31", d, 8'h61);
    osc_tick = 1; @(negedge clk); osc_tick = 0;
    rd(8'h4F, d); check("R3 osc flag at 32", d, 8'hE1);
    push_exp(8'h3C); collect("R7 osc result");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule